// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

This block turns one of four timekeeping strobes into a request on a single active-low status line. The strobes are a 64 Hz tick from the prescaler and the carries out of the seconds, minutes and hours counters. A 4-bit control word chooses which strobe is the source. It also selects one of two behaviours and holds a bit that keeps the line quiet. In latched behaviour, each selected strobe sets a pending flag. The flag, and with it the line, stays active until software writes a zero to it. In pulse behaviour, the flag and the line go active for a fixed number of clock cycles, and the flag then clears itself.

The line is modelled as an active-low value plus an output enable. The enable stands in for an open-drain driver. The pending flag can be read back directly. The quiet bit only gates the line: events still set the flag while the line is gated. If the flag is still set when the quiet bit is cleared, the line asserts. Bus decoding and the timekeeping counters sit outside this block.

Top module: `tick_irq_gen`

## Requirements
- R1: After synchronous reset the flag reads 0, the line is released (`irq_oe_o`=0, `irq_n_o`=1), and the control word is 4'b0001: source 00, pulse behaviour, line gated.
- R2: Control bits [3:2] pick the source: 00 selects the 64 Hz tick, 01 the seconds carry, 10 the minutes carry and 11 the hours carry. A source that is high on a clock edge sets the flag, which reads 1 after that edge. A control write uses its new value from the next cycle on.
- R3: Strobes on the sources that are not selected never set the flag.
- R4: With control bit [1] = 1 (latched behaviour), the flag stays set until software clears it, however long that takes.
- R5: A flag write (`flag_wr_i`) with data 0 clears the flag at that edge. A flag write with data 1 has no effect.
- R6: When a selected strobe and a clearing flag write arrive on the same edge, the flag ends up set.
- R7: With control bit [1] = 0 (pulse behaviour), one event holds the flag high for exactly PULSE_CYC cycles, after which it clears itself.
- R8: In pulse behaviour, an event that arrives while a pulse is in progress restarts the full PULSE_CYC count.
- R9: With control bit [0] = 1, the line stays released, but events still set the flag.
- R10: Clearing control bit [0] while the flag is set drives the line low from the next cycle.
- R11: Whenever the flag is set and control bit [0] is 0, the line is driven low (`irq_oe_o`=1, `irq_n_o`=0). Otherwise it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick64_i | input | 1 | 64 Hz strobe, one cycle wide |
| sec_carry_i | input | 1 | Seconds-counter carry strobe |
| min_carry_i | input | 1 | Minutes-counter carry strobe |
| hour_carry_i | input | 1 | Hours-counter carry strobe |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 4 | Control word: [3:2] source, [1] latched, [0] gate |
| flag_wr_i | input | 1 | Pending-flag write strobe |
| flag_wdata_i | input | 1 | Pending-flag write data (only 0 acts) |
| flag_o | output | 1 | Pending-flag readout |
| irq_n_o | output | 1 | Line value, active low |
| irq_oe_o | output | 1 | Line output enable (1 = pulling low) |

## Verification
The stimulus fires every source strobe under every source selection. This shows that only the selected carry raises the flag, and that a strobe on an unselected carry has no effect. Pulse behaviour is tried with isolated ticks, which fixes the exact width, and with a tick landing mid-pulse, which separates a restart from an extension or an ignored event. Latched behaviour is tried with long waits, writes of one, writes of zero, and a zero write that coincides with an event. Together these separate self-clearing from software clearing and show which side wins a tie. Gating is exercised both while a pulse is running and while a latched flag is pending. This shows that the line is suppressed without the flag being lost.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

    typedef enum logic [1:0] {
        SRC_TICK64 = 2'd0,
        SRC_SEC    = 2'd1,
        SRC_MIN    = 2'd2,
        SRC_HOUR   = 2'd3
    } src_sel_e;

    typedef struct packed {
        src_sel_e sel;
        logic     latched;
        logic     gate;
    } ctrl_t;

    typedef struct packed {
        logic hour;
        logic min;
        logic sec;
        logic tick64;
    } strobes_t;

    localparam ctrl_t CTRL_RESET = '{sel: SRC_TICK64, latched: 1'b0, gate: 1'b1};

    function automatic ctrl_t decode_ctrl(input logic [3:0] raw);
        ctrl_t c;
        c.sel     = src_sel_e'(raw[3:2]);
        c.latched = raw[1];
        c.gate    = raw[0];
        return c;
    endfunction

    function automatic logic pick_strobe(input strobes_t s, input src_sel_e sel);
        logic r;
        unique case (sel)
            SRC_TICK64: r = s.tick64;
            SRC_SEC:    r = s.sec;
            SRC_MIN:    r = s.min;
            SRC_HOUR:   r = s.hour;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tick_irq_src_sel.sv
module tick_irq_src_sel
    import tick_irq_pkg::*;
(
    input  strobes_t strobes_i,
    input  src_sel_e sel_i,
    output logic     event_o
);
    always_comb begin
        event_o = pick_strobe(strobes_i, sel_i);
    end
endmodule

// File: rtl/tick_irq_pulse_timer.sv
module tick_irq_pulse_timer #(
    parameter int PULSE_CYC = 16,
    parameter int CNT_W     = $clog2(PULSE_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = run_i && (cnt_q == '0) && !load_i;
    assign count_o  = cnt_q;
endmodule

// File: rtl/tick_irq_flag.sv
module tick_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic event_i,
    input  logic sw_clear_i,
    input  logic expire_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (event_i) begin
            flag_q <= 1'b1;
        end else if (sw_clear_i || expire_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
    import tick_irq_pkg::*;
#(
    parameter int PULSE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick64_i,
    input  logic       sec_carry_i,
    input  logic       min_carry_i,
    input  logic       hour_carry_i,
    input  logic       ctrl_wr_i,
    input  logic [3:0] ctrl_wdata_i,
    input  logic       flag_wr_i,
    input  logic       flag_wdata_i,
    output logic       flag_o,
    output logic       irq_n_o,
    output logic       irq_oe_o
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    ctrl_t            ctrl_q;
    strobes_t         strobes;
    logic             event_sel;
    logic             sw_clear;
    logic             expire;
    logic             flag_q;
    logic             run_pulse;
    logic             line_active;
    logic [CNT_W-1:0] pulse_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_wr_i) begin
            ctrl_q <= decode_ctrl(ctrl_wdata_i);
        end
    end

    always_comb begin
        strobes.tick64 = tick64_i;
        strobes.sec    = sec_carry_i;
        strobes.min    = min_carry_i;
        strobes.hour   = hour_carry_i;
    end

    tick_irq_src_sel u_src (
        .strobes_i (strobes),
        .sel_i     (ctrl_q.sel),
        .event_o   (event_sel)
    );

    assign sw_clear  = flag_wr_i && !flag_wdata_i;
    assign run_pulse = flag_q && !ctrl_q.latched;

    tick_irq_pulse_timer #(
        .PULSE_CYC (PULSE_CYC),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (event_sel),
        .run_i    (run_pulse),
        .expire_o (expire),
        .count_o  (pulse_cnt)
    );

    tick_irq_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .event_i    (event_sel),
        .sw_clear_i (sw_clear),
        .expire_i   (expire),
        .flag_o     (flag_q)
    );

    assign line_active = flag_q && !ctrl_q.gate;
    assign flag_o      = flag_q;
    assign irq_oe_o    = line_active;
    assign irq_n_o     = !line_active;
endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk #(
    parameter int PULSE_CYC = 16,
    parameter int CNT_W     = $clog2(PULSE_CYC + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             tick64_i,
    input logic             sec_carry_i,
    input logic             min_carry_i,
    input logic             hour_carry_i,
    input logic             flag_wr_i,
    input logic             flag_wdata_i,
    input logic [3:0]       ctrl_bits,
    input logic [CNT_W-1:0] cnt_q,
    input logic             flag_o,
    input logic             irq_n_o,
    input logic             irq_oe_o
);
    logic ev;
    logic any_strobe;
    logic zero_wr;

    assign ev = (ctrl_bits[3:2] == 2'd0 && tick64_i) || (ctrl_bits[3:2] == 2'd1 && sec_carry_i)
             || (ctrl_bits[3:2] == 2'd2 && min_carry_i) || (ctrl_bits[3:2] == 2'd3 && hour_carry_i);
    assign any_strobe = tick64_i || sec_carry_i || min_carry_i || hour_carry_i;
    assign zero_wr    = flag_wr_i && !flag_wdata_i;

    assert_set_R2: assert property (@(posedge clk) disable iff (rst) ev |=> flag_o);
    assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && !any_strobe) |=> !flag_o);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_o && ctrl_bits[1] && !zero_wr) |=> flag_o);
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (zero_wr && !ev) |=> !flag_o);
    assert_race_R6: assert property (@(posedge clk) disable iff (rst)
        (zero_wr && ev) |=> flag_o);
    assert_end_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !ctrl_bits[1] && cnt_q == '0 && !ev) |=> !flag_o);
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (ev && !ctrl_bits[1]) |=> (cnt_q == CNT_W'(PULSE_CYC - 1)));
    assert_gate_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_bits[0] |-> (!irq_oe_o && irq_n_o));
    assert_ungate_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctrl_bits[0]) && flag_o) |-> (irq_oe_o && !irq_n_o));
endmodule

bind tick_irq_gen tick_irq_chk #(.PULSE_CYC(PULSE_CYC), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick64_i     (tick64_i),
    .sec_carry_i  (sec_carry_i),
    .min_carry_i  (min_carry_i),
    .hour_carry_i (hour_carry_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .ctrl_bits    (ctrl_q),
    .cnt_q        (pulse_cnt),
    .flag_o       (flag_o),
    .irq_n_o      (irq_n_o),
    .irq_oe_o     (irq_oe_o)
);

// File: tb/tick_irq_gen_tb.sv
module tick_irq_gen_tb;
    localparam int PW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick64 = 0, sec_c = 0, min_c = 0, hour_c = 0;
    logic ctrl_wr = 0, flag_wr = 0, flag_wd = 0;
    logic [3:0] ctrl_wd = '0;
    logic flag, irq_n, irq_oe;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    int  m_flag = 0;
    int  m_left = 0;
    int  m_src = 0, m_latched = 0, m_gate = 1;

    always #2 clk = ~clk;

    tick_irq_gen #(.PULSE_CYC(PW)) u_dut (
        .clk(clk), .rst(rst), .tick64_i(tick64), .sec_carry_i(sec_c),
        .min_carry_i(min_c), .hour_carry_i(hour_c), .ctrl_wr_i(ctrl_wr),
        .ctrl_wdata_i(ctrl_wd), .flag_wr_i(flag_wr), .flag_wdata_i(flag_wd),
        .flag_o(flag), .irq_n_o(irq_n), .irq_oe_o(irq_oe)
    );

    always @(posedge clk) begin
        int strobe_hit;
        if (rst) begin
            m_flag = 0; m_left = 0; m_src = 0; m_latched = 0; m_gate = 1;
        end else begin
            case (m_src)
                0: strobe_hit = tick64;
                1: strobe_hit = sec_c;
                2: strobe_hit = min_c;
                default: strobe_hit = hour_c;
            endcase
            if (strobe_hit != 0) begin
                m_flag = 1;
                m_left = PW;
            end else if (flag_wr && !flag_wd) begin
                m_flag = 0;
            end else if (m_flag == 1 && m_latched == 0) begin
                m_left = m_left - 1;
                if (m_left <= 0) m_flag = 0;
            end
            if (ctrl_wr) begin
                m_src = ctrl_wd[3:2]; m_latched = ctrl_wd[1]; m_gate = ctrl_wd[0];
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare outputs against the model on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_drive;
            exp_drive = (m_flag == 1 && m_gate == 0) ? 1 : 0;
            check(cur_req, flag, m_flag, "flag");
            check("R11", irq_oe, exp_drive, "line enable");
            check("R11", irq_n, 1 - exp_drive, "line value");
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        tick64 = (which == 0); sec_c = (which == 1);
        min_c = (which == 2); hour_c = (which == 3);
        @(negedge clk);
        tick64 = 0; sec_c = 0; min_c = 0; hour_c = 0;
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        @(negedge clk);
        ctrl_wr = 1; ctrl_wd = v;
        @(negedge clk);
        ctrl_wr = 0;
    endtask

    task automatic wr_flag(input logic v);
        @(negedge clk);
        flag_wr = 1; flag_wd = v;
        @(negedge clk);
        flag_wr = 0;
    endtask

    initial begin
        int hi;
        idle(3);
        rst = 0;
        @(negedge clk);
        cur_req = "R1";
        check("R1", flag, 0, "flag after reset");
        check("R1", irq_oe, 0, "enable after reset");
        check("R1", irq_n, 1, "value after reset");
        // gated by default: a tick sets flag but the line stays released
        cur_req = "R9";
        strobe(0);
        check("R9", flag, 1, "flag set while gated");
        check("R9", irq_oe, 0, "line released while gated");
        idle(PW + 4);

        // pulse behaviour, source 00, ungated: exact width
        wr_ctrl(4'b0000);
        cur_req = "R7";
        for (int k = 0; k < 3; k++) begin
            strobe(0);
            hi = 0;
            for (int c = 0; c < PW + 6; c++) begin
                if (flag) hi++;
                @(negedge clk);
            end
            check("R7", hi, PW, "pulse width");
            idle(10);
        end

        // retrigger mid-pulse
        cur_req = "R8";
        strobe(0);
        idle(5);
        strobe(0);
        hi = 0;
        for (int c = 0; c < PW + 6; c++) begin
            if (flag) hi++;
            @(negedge clk);
        end
        check("R8", hi, PW, "width after restart");

        // latched behaviour on seconds carry
        wr_ctrl(4'b0110);
        cur_req = "R3";
        strobe(0); strobe(2); strobe(3);
        idle(2);
        check("R3", flag, 0, "unselected strobes");
        cur_req = "R4";
        strobe(1);
        idle(60);
        check("R4", flag, 1, "latched flag held");
        check("R4", irq_n, 0, "line low while latched");
        cur_req = "R5";
        wr_flag(1'b1);
        idle(1);
        check("R5", flag, 1, "write of one ignored");
        wr_flag(1'b0);
        check("R5", flag, 0, "write of zero clears");
        // event coinciding with a clear
        cur_req = "R6";
        @(negedge clk);
        sec_c = 1; flag_wr = 1; flag_wd = 0;
        @(negedge clk);
        sec_c = 0; flag_wr = 0;
        check("R6", flag, 1, "set wins over clear");
        wr_flag(1'b0);

        // each selection responds only to its own carry
        cur_req = "R2";
        for (int s = 0; s < 4; s++) begin
            wr_ctrl({2'(s), 2'b10});
            for (int o = 0; o < 4; o++) begin
                if (o != s) strobe(o);
            end
            idle(1);
            check("R2", flag, 0, "other carries under selection");
            strobe(s);
            check("R2", flag, 1, "selected carry");
            wr_flag(1'b0);
        end

        // gate a pending latched flag, then release the gate
        cur_req = "R9";
        wr_ctrl(4'b1111);
        strobe(3);
        idle(3);
        check("R9", flag, 1, "flag set while gated");
        check("R9", irq_oe, 0, "line released while gated");
        cur_req = "R10";
        wr_ctrl(4'b1110);
        check("R10", irq_oe, 1, "line driven after ungating");
        check("R10", irq_n, 0, "line low after ungating");
        wr_flag(1'b0);

        // gated pulse behaviour
        cur_req = "R9";
        wr_ctrl(4'b0001);
        strobe(0);
        idle(PW + 4);
        strobe(0);
        idle(4);
        wr_ctrl(4'b0000);
        cur_req = "R10";
        idle(PW + 4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule